// File: doc/BRIEF.md
# Unaligned Access Splitter for a Two-Bank 16-bit Bus

This block sits between a CPU's data port and a 16-bit memory built from two 8-bit banks. The CPU asks for a byte, a word or a double word at any 24-bit byte address, with no alignment rule. The block turns that request into a short run of bus cycles. Each cycle is one of three kinds: even byte, odd byte or even word. For each cycle it drives the word address, the A0 line, an active-low high-byte enable and the write data on the correct byte lanes. On reads it collects the returned bytes into one result.

Both banks receive the word address (byte address bits 23..1). The low bank sits on data lines 7..0 and responds when A0 is low. The high bank sits on lines 15..8 and responds when the high-byte enable is low. The bus side finishes each cycle with a one-clock done strobe. The block reports completion with a one-clock pulse.

Top module: `unaligned_bus_splitter`

## Requirements
- R1: While reset is held and on the first clock after it, bus_valid is 0, rsp_done is 0, rsp_rdata is 0 and bus_hbe_n is 1.
- R2: Cycle encodings are fixed. An even byte drives bus_a0=0 and bus_hbe_n=1. An odd byte drives bus_a0=1 and bus_hbe_n=0. An even word drives bus_a0=0 and bus_hbe_n=0. The pair bus_a0=1 with bus_hbe_n=1 never appears while bus_valid is 1.
- R3: Each cycle's kind depends on the current byte address and the bytes still to move. An odd address gives an odd byte. An even address with two or more bytes left gives an even word. Otherwise the cycle is an even byte. bus_waddr is the current byte address shifted right by one. An odd byte cycle can therefore only be the first cycle of a request.
- R4: req_size codes the request length: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes.
- R5: On writes, byte k of req_wdata (bits 8k+7..8k) goes to byte address addr+k, with the least-significant byte at the lowest address. An odd-addressed byte travels on bus_wdata[15:8]. An even-addressed byte travels on bus_wdata[7:0]. In an even word the lower address is on [7:0]. A lane that carries no data is driven to 0.
- R6: On reads, rsp_rdata byte k holds the byte read from address addr+k. An odd byte is taken from bus_rdata[15:8] and an even byte from bus_rdata[7:0]. Bytes above the request length are 0.
- R7: bus_valid rises on the clock after a start is accepted. Each cycle's outputs hold until bus_done is sampled high. The next cycle appears on the following clock. After the last cycle's done, bus_valid falls and rsp_done is 1 for exactly one clock.
- R8: req_start is ignored while bus_valid is 1, and bus_done is ignored while bus_valid is 0.
- R9: A start presented in the same clock that rsp_done is high is accepted.
- R10: The byte address wraps modulo 2^24, so an access at the top of the space continues at word address 0.
- R11: bus_write follows req_write for the whole request. A write completion leaves rsp_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a request (taken only when idle) |
| req_addr | input | 24 | Byte address of the first byte |
| req_size | input | 2 | Length code: 0 byte, 1 word, 2/3 double word |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, least-significant byte at lowest address |
| bus_done | input | 1 | Current bus cycle completes at this clock |
| bus_rdata | input | 16 | Read data from both banks |
| bus_valid | output | 1 | A bus cycle is being presented |
| bus_waddr | output | 23 | Word address (byte address bits 23..1) |
| bus_a0 | output | 1 | Address bit 0; low enables the low bank |
| bus_hbe_n | output | 1 | Active-low high-byte enable |
| bus_write | output | 1 | Direction of the current cycles |
| bus_wdata | output | 16 | Lane-steered write data |
| rsp_rdata | output | 32 | Assembled read result |
| rsp_done | output | 1 | One-clock completion pulse |

## Verification
Two events can land in the same clock: the completion pulse of one request and the acceptance of the next start. The bench provokes this by raising req_start exactly in the clock where rsp_done is high. It then expects the new request's first cycle on the next clock, with the right kind and word address. It also checks that the finished read result is still held. A related overlap is a start raised while a cycle is waiting for its done strobe. The bench checks that the running cycle's address and enables stay unchanged and that the stray start leaves no trace.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

  typedef enum logic [1:0] {
    CYC_EVEN_BYTE = 2'd0,
    CYC_ODD_BYTE  = 2'd1,
    CYC_EVEN_WORD = 2'd2
  } cyc_kind_t;

  // Largest request is a double word.
  localparam int REQ_BYTES = 4;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ubs_cycle_pick.sv
module ubs_cycle_pick
  import ubs_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             odd_addr,
  input  logic [CNT_W-1:0] remain,
  output cyc_kind_t        kind,
  output logic             a0,
  output logic             hbe_n,
  output logic [CNT_W-1:0] consume
);

  always_comb begin
    if (odd_addr)
      kind = CYC_ODD_BYTE;
    else if (remain >= CNT_W'(2))
      kind = CYC_EVEN_WORD;
    else
      kind = CYC_EVEN_BYTE;
    a0      = (kind == CYC_ODD_BYTE);
    hbe_n   = (kind == CYC_EVEN_BYTE);
    consume = (kind == CYC_EVEN_WORD) ? CNT_W'(2) : CNT_W'(1);
  end

endmodule

// File: rtl/ubs_lane_steer.sv
module ubs_lane_steer
  import ubs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  cyc_kind_t                    kind,
  input  logic [$clog2(NBYTES)-1:0]    idx,
  input  logic [NBYTES*BYTE_W-1:0]     data,
  output logic [2*BYTE_W-1:0]          lanes
);

  localparam int IDX_W = $clog2(NBYTES);

  logic [BYTE_W-1:0] src [NBYTES];
  logic [IDX_W-1:0]  idx_hi;

  for (genvar b = 0; b < NBYTES; b++) begin : g_src
    assign src[b] = data[b*BYTE_W +: BYTE_W];
  end

  assign idx_hi = idx + IDX_W'(1);

  always_comb begin
    lanes = '0;
    case (kind)
      CYC_EVEN_BYTE: lanes[BYTE_W-1:0]        = src[idx];
      CYC_ODD_BYTE:  lanes[2*BYTE_W-1:BYTE_W] = src[idx];
      CYC_EVEN_WORD: lanes                    = {src[idx_hi], src[idx]};
      default:       lanes                    = '0;
    endcase
  end

endmodule

// File: rtl/ubs_read_merge.sv
module ubs_read_merge
  import ubs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         capture,
  input  cyc_kind_t                    kind,
  input  logic [$clog2(NBYTES)-1:0]    idx,
  input  logic [2*BYTE_W-1:0]          rdata,
  output logic [NBYTES*BYTE_W-1:0]     merged
);

  localparam int IDX_W = $clog2(NBYTES);

  logic [NBYTES*BYTE_W-1:0] acc_q;
  logic [IDX_W-1:0]         idx_hi;
  logic [BYTE_W-1:0]        rd_lo, rd_hi;

  assign idx_hi = idx + IDX_W'(1);
  assign rd_lo  = rdata[BYTE_W-1:0];
  assign rd_hi  = rdata[2*BYTE_W-1:BYTE_W];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] nb;
    always_comb begin
      nb = acc_q[b*BYTE_W +: BYTE_W];
      if (capture) begin
        if (kind == CYC_ODD_BYTE && idx == IDX_W'(b))
          nb = rd_hi;
        else if (kind != CYC_ODD_BYTE && idx == IDX_W'(b))
          nb = rd_lo;
        else if (kind == CYC_EVEN_WORD && idx_hi == IDX_W'(b))
          nb = rd_hi;
      end
    end
    assign merged[b*BYTE_W +: BYTE_W] = nb;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      acc_q <= '0;
    else if (capture)
      acc_q <= merged;
  end

  AST_CLEAR_CAPTURE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(clear && capture)); // R6

endmodule

// File: rtl/unaligned_bus_splitter.sv
module unaligned_bus_splitter
  import ubs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_start,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  req_size,
  input  logic                        req_write,
  input  logic [REQ_BYTES*BYTE_W-1:0] req_wdata,
  input  logic                        bus_done,
  input  logic [2*BYTE_W-1:0]         bus_rdata,
  output logic                        bus_valid,
  output logic [ADDR_W-2:0]           bus_waddr,
  output logic                        bus_a0,
  output logic                        bus_hbe_n,
  output logic                        bus_write,
  output logic [2*BYTE_W-1:0]         bus_wdata,
  output logic [REQ_BYTES*BYTE_W-1:0] rsp_rdata,
  output logic                        rsp_done
);

  localparam int REQ_W = REQ_BYTES * BYTE_W;
  localparam int IDX_W = $clog2(REQ_BYTES);
  localparam int CNT_W = $clog2(REQ_BYTES + 1);

  // Request state
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [CNT_W-1:0]  remain_q, nxt_remain;
  logic [IDX_W-1:0]  idx_q, nxt_idx;
  logic [REQ_W-1:0]  wdata_q, nxt_wdata;
  cyc_kind_t         kind_q;
  logic [CNT_W-1:0]  consume_q;

  logic load, step, last;

  cyc_kind_t        pick_kind;
  logic             pick_a0, pick_hbe_n;
  logic [CNT_W-1:0] pick_consume;
  logic [2*BYTE_W-1:0] steer_lanes;
  logic [REQ_W-1:0] merged;

  assign load = !bus_valid && req_start;
  assign step = bus_valid && bus_done;
  assign last = step && (remain_q == consume_q);

  always_comb begin
    nxt_addr   = addr_q;
    nxt_remain = remain_q;
    nxt_idx    = idx_q;
    nxt_wdata  = wdata_q;
    if (load) begin
      nxt_addr   = req_addr;
      nxt_remain = CNT_W'(size_to_bytes(req_size));
      nxt_idx    = '0;
      nxt_wdata  = req_wdata;
    end else if (step) begin
      nxt_addr   = addr_q + ADDR_W'(consume_q);
      nxt_remain = remain_q - consume_q;
      nxt_idx    = idx_q + IDX_W'(consume_q);
    end
  end

  // Kind and enables of the cycle to present next.
  ubs_cycle_pick #(.CNT_W(CNT_W)) u_pick (
    .odd_addr (nxt_addr[0]),
    .remain   (nxt_remain),
    .kind     (pick_kind),
    .a0       (pick_a0),
    .hbe_n    (pick_hbe_n),
    .consume  (pick_consume)
  );

  ubs_lane_steer #(.BYTE_W(BYTE_W), .NBYTES(REQ_BYTES)) u_steer (
    .kind  (pick_kind),
    .idx   (nxt_idx),
    .data  (nxt_wdata),
    .lanes (steer_lanes)
  );

  ubs_read_merge #(.BYTE_W(BYTE_W), .NBYTES(REQ_BYTES)) u_merge (
    .clk     (clk),
    .rst     (rst),
    .clear   (load),
    .capture (step),
    .kind    (kind_q),
    .idx     (idx_q),
    .rdata   (bus_rdata),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_a0    <= 1'b0;
      bus_hbe_n <= 1'b1;
      bus_wdata <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      addr_q    <= '0;
      remain_q  <= '0;
      idx_q     <= '0;
      wdata_q   <= '0;
      kind_q    <= CYC_EVEN_BYTE;
      consume_q <= CNT_W'(1);
    end else begin
      rsp_done <= last;
      if (load) begin
        bus_valid <= 1'b1;
        bus_write <= req_write;
      end else if (last) begin
        bus_valid <= 1'b0;
      end
      if (load || step) begin
        addr_q    <= nxt_addr;
        remain_q  <= nxt_remain;
        idx_q     <= nxt_idx;
        wdata_q   <= nxt_wdata;
        kind_q    <= pick_kind;
        consume_q <= pick_consume;
        bus_a0    <= pick_a0;
        bus_hbe_n <= pick_hbe_n;
        bus_wdata <= steer_lanes;
      end
      if (last && !bus_write)
        rsp_rdata <= merged;
    end
  end

  assign bus_waddr = addr_q[ADDR_W-1:1];

  AST_LANE_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !(bus_a0 && bus_hbe_n)); // R2

  AST_ODD_ONLY_FIRST: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_a0) |-> (idx_q == '0)); // R3

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_waddr) && $stable(bus_a0)
                                   && $stable(bus_hbe_n) && $stable(bus_wdata))); // R7

  AST_DONE_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R7

  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |-> ($past(bus_valid && bus_done) && !bus_valid)); // R7

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!bus_valid && !req_start) |=> (!bus_valid && !rsp_done)); // R8

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !last) |=> $stable(bus_write)); // R11

endmodule

// File: tb/unaligned_bus_splitter_test.sv
module unaligned_bus_splitter_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        bus_done = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_valid;
  logic [22:0] bus_waddr;
  logic        bus_a0, bus_hbe_n, bus_write;
  logic [15:0] bus_wdata;
  logic [31:0] rsp_rdata;
  logic        rsp_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] last_rd = '0;

  always #(CLK_P/2) clk = ~clk;

  unaligned_bus_splitter uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_valid(bus_valid),
    .bus_waddr(bus_waddr), .bus_a0(bus_a0), .bus_hbe_n(bus_hbe_n),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[23:16] ^ 8'h3C;
  endfunction

  // Memory model: low lane even address, high lane odd address.
  assign bus_rdata = {mem_byte({bus_waddr, 1'b1}), mem_byte({bus_waddr, 1'b0})};

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // kinds per cycle (2 bits each, cycle 0 in bits 1:0): 0 even byte, 1 odd byte, 2 even word
  task automatic run_req(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                         input logic [31:0] wd, input int ncyc, input logic [5:0] kinds,
                         input int waits, input bit b2b, input bit poke);
    logic [23:0] cur;
    int          idx;
    int          nb;
    logic [31:0] exp_rd;
    if (!b2b) begin
      @(negedge clk);
      chk("R7", "rsp_done low between requests", 64'(rsp_done), 64'd0);
    end
    req_start = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_start = 1'b0; req_wdata = 32'h0BAD0BAD; req_addr = 24'h5A5A5A;
    cur = a; idx = 0;
    for (int c = 0; c < ncyc; c++) begin
      logic [1:0]  k;
      logic [15:0] lanes;
      logic [7:0]  b0, b1;
      k = kinds[2*c +: 2];
      chk("R7", "bus_valid during cycle", 64'(bus_valid), 64'd1);
      chk("R2", "a0/hbe_n pair", 64'({bus_a0, bus_hbe_n}),
          64'({(k == 2'd1), (k == 2'd0)}));
      chk("R3", "word address", 64'(bus_waddr), 64'(cur[23:1]));
      chk("R11", "bus_write", 64'(bus_write), 64'(wr));
      if (wr) begin
        b0 = wd[8*idx +: 8];
        b1 = (idx < 3) ? wd[8*(idx+1) +: 8] : 8'h00;
        case (k)
          2'd0:    lanes = {8'h00, b0};
          2'd1:    lanes = {b0, 8'h00};
          default: lanes = {b1, b0};
        endcase
        chk("R5", "write lanes", 64'(bus_wdata), 64'(lanes));
      end
      if (poke && c == 0) begin
        req_start = 1'b1; req_addr = 24'h00ABCD; req_size = 2'd0;
      end
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        req_start = 1'b0;
        chk("R7", "held address", 64'(bus_waddr), 64'(cur[23:1]));
        chk("R8", "held enables", 64'({bus_valid, bus_a0, bus_hbe_n}),
            64'({1'b1, (k == 2'd1), (k == 2'd0)}));
      end
      req_start = 1'b0;
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
      cur = cur + ((k == 2'd2) ? 24'd2 : 24'd1);
      idx = idx + ((k == 2'd2) ? 2 : 1);
    end
    chk("R7", "completion {bus_valid,rsp_done}", 64'({bus_valid, rsp_done}), 64'b01);
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    chk("R4", "bytes moved", 64'(idx), 64'(nb));
    if (!wr) begin
      exp_rd = '0;
      for (int i = 0; i < nb; i++) exp_rd[8*i +: 8] = mem_byte(a + 24'(i));
      chk("R6", "read result", 64'(rsp_rdata), 64'(exp_rd));
      last_rd = exp_rd;
    end else begin
      chk("R11", "read result kept on write", 64'(rsp_rdata), 64'(last_rd));
    end
  endtask

  typedef struct packed {
    logic [23:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic [1:0]  ncyc;
    logic [5:0]  kinds;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{24'h000100, 2'd0, 1'b0, 32'h0,        2'd1, 6'b000000},
    '{24'h000101, 2'd0, 1'b0, 32'h0,        2'd1, 6'b000001},
    '{24'h000200, 2'd1, 1'b0, 32'h0,        2'd1, 6'b000010},
    '{24'h000203, 2'd1, 1'b0, 32'h0,        2'd2, 6'b000001},
    '{24'h000400, 2'd2, 1'b0, 32'h0,        2'd2, 6'b001010},
    '{24'h000405, 2'd2, 1'b0, 32'h0,        2'd3, 6'b001001},
    '{24'h001000, 2'd0, 1'b1, 32'h776655AB, 2'd1, 6'b000000},
    '{24'h001001, 2'd0, 1'b1, 32'h998877CD, 2'd1, 6'b000001},
    '{24'h001002, 2'd1, 1'b1, 32'h4321BEEF, 2'd1, 6'b000010},
    '{24'h001007, 2'd1, 1'b1, 32'h8765CAFE, 2'd2, 6'b000001},
    '{24'h002000, 2'd2, 1'b1, 32'h12345678, 2'd2, 6'b001010},
    '{24'h002003, 2'd2, 1'b1, 32'hDEADBEEF, 2'd3, 6'b001001},
    '{24'h000011, 2'd3, 1'b0, 32'h0,        2'd3, 6'b001001}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", 64'({bus_valid, rsp_done, bus_hbe_n}), 64'b001);
    chk("R1", "reset rsp_rdata", 64'(rsp_rdata), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "first clock after reset", 64'({bus_valid, rsp_done, bus_hbe_n}), 64'b001);

    foreach (VECS[i])
      run_req(VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].wdata,
              int'(VECS[i].ncyc), VECS[i].kinds, i % 3, 1'b0, 1'b0);

    // R10: wrap at the top of the address space
    run_req(24'hFFFFFF, 2'd1, 1'b0, 32'h0,        2, 6'b000001, 1, 1'b0, 1'b0);
    run_req(24'hFFFFFE, 2'd2, 1'b0, 32'h0,        2, 6'b001010, 0, 1'b0, 1'b0);
    run_req(24'hFFFFFD, 2'd2, 1'b1, 32'hA1B2C3D4, 3, 6'b001001, 2, 1'b0, 1'b0);

    // R9: start in the same clock as rsp_done
    run_req(24'h000300, 2'd2, 1'b0, 32'h0, 2, 6'b001010, 0, 1'b0, 1'b0);
    run_req(24'h000301, 2'd1, 1'b0, 32'h0, 2, 6'b000001, 1, 1'b1, 1'b0);
    run_req(24'h000600, 2'd0, 1'b1, 32'h000000EE, 1, 6'b000000, 0, 1'b1, 1'b0);

    // R8: start while busy is ignored
    run_req(24'h000501, 2'd2, 1'b0, 32'h0, 3, 6'b001001, 2, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8", "stray start left no request", 64'(bus_valid), 64'd0);

    // R8: bus_done while idle is ignored
    bus_done = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "idle done {bus_valid,rsp_done}", 64'({bus_valid, rsp_done}), 64'b00);
    bus_done = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule